// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This controller sits between a host and a nonvolatile byte array and lets the host treat the array like a static RAM for reads. Writes are not applied straight away. Each host write strobe drops one byte into a page register that holds a whole page. The page is selected by the upper address bits, and the lower bits give the byte offset within it. The host can load bytes in any order. Once no further byte has arrived for a programmable number of clock cycles, the page is closed and a programming period starts. During that period the controller copies every loaded byte into the array, and it copies only those bytes.

While programming is under way, the controller holds `busy` high and ignores write strobes. Reads return a status byte instead of array contents. In the status byte, bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 is a flag that flips on each read, and bits 5..0 are copied from the last accepted byte. When the programming timer expires, reads return array data again and a new page load may begin.

Both timing values are parameters counted in clock cycles: the byte-load window `LOAD_WIN` and the programming duration `PROG_CYC`. Reads use a synchronous array port, so read data is available one cycle after the read strobe.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `arr_we` are 0.
- R2: When not busy, a read strobe on `host_addr` causes `rd_valid` to be 1 in the next cycle, and `host_rdata` then holds the array byte at that address.
- R3: Bytes may be loaded in any order, and a repeated offset keeps its newest value. Only loaded offsets are programmed, and the other bytes of the page keep their array contents.
- R4: The first accepted strobe fixes the page (address bits 16..7). A strobe carrying a different page during the load is ignored, and the loaded bytes stay intact.
- R5: A matching strobe is accepted if it arrives up to `LOAD_WIN` cycles after the previous accepted strobe, and it restarts the window. If no strobe is accepted for `LOAD_WIN` cycles, `busy` rises exactly `LOAD_WIN` cycles after the last accepted strobe edge.
- R6: `busy` stays high for exactly `PROG_CYC` cycles, and `arr_we` is only ever asserted while `busy` is high.
- R7: A read while busy returns a status byte. Bit 7 of that byte is the inverse of bit 7 of the last accepted byte, and bits 5..0 equal bits 5..0 of that byte.
- R8: Bit 6 of the status byte is 0 on the first read of each programming period and flips on every later read in that period.
- R9: Write strobes during programming are ignored: they neither change the array nor add to the page.
- R10: Once `busy` falls, reads return the programmed data, and a new write strobe starts a new page load.
- R11: In one programming period, `arr_we` pulses exactly once per distinct loaded offset, and every pulse addresses the latched page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 17 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe, one per byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read result, valid while rd_valid |
| rd_valid | output | 1 | Read result available (one cycle after host_rd) |
| busy | output | 1 | Programming period in progress |
| arr_addr | output | 17 | Array address for reads and commits |
| arr_wdata | output | 8 | Byte committed to the array |
| arr_we | output | 1 | Array byte write enable |
| arr_re | output | 1 | Array read enable, data expected next cycle |
| arr_rdata | input | 8 | Array read data, one cycle after arr_re |

## Verification
A read result is due one cycle after the edge that samples its strobe. The driver therefore pushes the expected byte into a queue when it raises `host_rd`, and the monitor pops and compares on the falling edge after `rd_valid` rises. Status bytes are predicted from the last byte the bench wrote and a bench-side copy of the flip flag. Timing checks count edges from the edge that sampled the last accepted strobe. `busy` is sampled low at `LOAD_WIN-1` edges and high at `LOAD_WIN` edges. The fall of `busy` is checked the same way at `PROG_CYC-1` and `PROG_CYC` edges after its rise. All samples are taken on the falling edge, half a cycle away from any register update.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgwr_state_e;
endpackage

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int PAGE_SIZE = 128,
  parameter int DW        = 8,
  localparam int OFS_W    = $clog2(PAGE_SIZE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [OFS_W-1:0] ld_ofs,
  input  logic [DW-1:0]    ld_data,
  input  logic             clr,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [DW-1:0]    rd_data,
  output logic             rd_hit
);
  logic [DW-1:0]        mem_q [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] mask_q, mask_d;

  for (genvar i = 0; i < PAGE_SIZE; i++) begin : g_byte
    logic wen;
    assign wen = ld_en && (ld_ofs == OFS_W'(i));
    always_ff @(posedge clk) begin
      if (wen) mem_q[i] <= ld_data;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (clr)        mask_d = '0;
    else if (ld_en) mask_d[ld_ofs] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rd_data = mem_q[rd_ofs];
  assign rd_hit  = mask_q[rd_ofs];

  // R3: an accepted byte is marked for programming
  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !clr) |=> mask_q[$past(ld_ofs)]);
  // R9: without a load the set of marked bytes cannot grow
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !clr) |=> ($countones(mask_q) == $countones($past(mask_q))));
endmodule

// File: rtl/pgwr_status.sv
module pgwr_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          cap_msb,
  input  logic [DW-3:0] cap_low,
  input  logic          tog_clr,
  input  logic          rd_stb,
  output logic [DW-1:0] stat
);
  logic          msb_q, msb_d;
  logic [DW-3:0] low_q, low_d;
  logic          tog_q, tog_d;

  always_comb begin
    msb_d = msb_q;
    low_d = low_q;
    if (cap_en) begin
      msb_d = cap_msb;
      low_d = cap_low;
    end
    tog_d = tog_q;
    if (tog_clr)     tog_d = 1'b0;
    else if (rd_stb) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0;
      low_q <= '0;
      tog_q <= 1'b0;
    end else begin
      msb_q <= msb_d;
      low_q <= low_d;
      tog_q <= tog_d;
    end
  end

  assign stat = {~msb_q, tog_q, low_q};

  // R8: every status read flips the toggle flag
  p_tog_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !tog_clr) |=> (tog_q != $past(tog_q)));
  // R8: a new programming period starts with the flag at 0
  p_tog_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tog_clr |=> !tog_q);
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DW        = 8,
  parameter int PAGE_SIZE = 128,
  parameter int LOAD_WIN  = 16,
  parameter int PROG_CYC  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DW-1:0]     host_rdata,
  output logic              rd_valid,
  output logic              busy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DW-1:0]     arr_wdata,
  output logic              arr_we,
  output logic              arr_re,
  input  logic [DW-1:0]     arr_rdata
);
  localparam int OFS_W  = $clog2(PAGE_SIZE);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CMAX   = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(LOAD_WIN - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SCAN_END  = CNT_W'(PAGE_SIZE);

  pgwr_state_e       st_q, st_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr;
  logic              accept;
  logic              page_match;
  logic              scanning;
  logic [OFS_W-1:0]  scan_ofs;
  logic [DW-1:0]     buf_data;
  logic              buf_hit;
  logic              buf_clr;
  logic              tog_clr;
  logic [DW-1:0]     stat_byte;
  logic              rv_q, sel_q;
  logic [DW-1:0]     stat_q, stat_d;

  assign busy       = (st_q == ST_PROG);
  assign page_match = (host_addr[ADDR_W-1:OFS_W] == page_q);
  assign accept     = host_wr && ((st_q == ST_IDLE) ||
                                  ((st_q == ST_LOAD) && page_match));

  // next state
  always_comb begin
    st_d   = st_q;
    page_d = page_q;
    case (st_q)
      ST_IDLE: begin
        if (host_wr) begin
          st_d   = ST_LOAD;
          page_d = host_addr[ADDR_W-1:OFS_W];
        end
      end
      ST_LOAD: begin
        if (!accept && (cnt == WIN_LAST)) st_d = ST_PROG;
      end
      ST_PROG: begin
        if (cnt == PROG_LAST) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
    end
  end

  assign cnt_clr = accept || (st_q == ST_IDLE) || (st_d != st_q);

  pgwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  // commit scan over the page during the first PAGE_SIZE cycles of programming
  assign scanning = busy && (cnt < SCAN_END);
  assign scan_ofs = cnt[OFS_W-1:0];
  assign buf_clr  = busy && (cnt == PROG_LAST);

  pgwr_page_buf #(.PAGE_SIZE(PAGE_SIZE), .DW(DW)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (accept),
    .ld_ofs  (host_addr[OFS_W-1:0]),
    .ld_data (host_wdata),
    .clr     (buf_clr),
    .rd_ofs  (scan_ofs),
    .rd_data (buf_data),
    .rd_hit  (buf_hit)
  );

  assign arr_we    = scanning && buf_hit;
  assign arr_wdata = buf_data;
  assign arr_addr  = busy ? {page_q, scan_ofs} : host_addr;
  assign arr_re    = host_rd && !busy;

  assign tog_clr = (st_q == ST_LOAD) && (st_d == ST_PROG);

  pgwr_status #(.DW(DW)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (accept),
    .cap_msb (host_wdata[DW-1]),
    .cap_low (host_wdata[DW-3:0]),
    .tog_clr (tog_clr),
    .rd_stb  (host_rd && busy),
    .stat    (stat_byte)
  );

  // read return path
  always_comb begin
    stat_d = stat_q;
    if (host_rd && busy) stat_d = stat_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      sel_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      rv_q   <= host_rd;
      sel_q  <= host_rd && busy;
      stat_q <= stat_d;
    end
  end

  assign rd_valid   = rv_q;
  assign host_rdata = sel_q ? stat_q : arr_rdata;

  // R6: array writes only inside the programming period
  p_we_in_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R6: the programming counter never passes its limit
  p_prog_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= PROG_LAST));
  // R5: the load window counter stays inside the window
  p_win_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD) |-> (cnt <= WIN_LAST));
  // R2: every read strobe yields a result one cycle later
  p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> rd_valid);
  // R11: the latched page does not move while programming
  p_page_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q));
  // R9: no array read is issued while programming
  p_no_arr_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arr_re);
endmodule

// File: tb/pgwr_ctrl_tb_top.sv
module pgwr_ctrl_tb_top;
  localparam int W = 16;
  localparam int P = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_wr, host_rd;
  logic [7:0]  host_rdata;
  logic        rd_valid, busy;
  logic [16:0] arr_addr;
  logic [7:0]  arr_wdata;
  logic        arr_we, arr_re;
  logic [7:0]  arr_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] amem [int];
  int         we_cnt = 0;
  int         we_badpage = 0;
  logic [9:0] exp_page = '0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         tog_m = 0;

  always #2 clk = ~clk;

  pgwr_ctrl #(.LOAD_WIN(W), .PROG_CYC(P)) dut_i (
    .clk, .rst_n, .host_addr, .host_wdata, .host_wr, .host_rd,
    .host_rdata, .rd_valid, .busy, .arr_addr, .arr_wdata, .arr_we,
    .arr_re, .arr_rdata
  );

  function automatic logic [7:0] aget(int a);
    if (amem.exists(a)) return amem[a];
    return 8'hFF;
  endfunction

  // array model: synchronous read, byte write
  always @(posedge clk) begin
    if (arr_we) begin
      amem[int'(arr_addr)] = arr_wdata;
      we_cnt = we_cnt + 1;
      if (arr_addr[16:7] != exp_page) we_badpage = we_badpage + 1;
    end
    if (arr_re) arr_rdata <= aget(int'(arr_addr));
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [16:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // status read: bench predicts the flag from its own copy
  task automatic rd_stat(logic [7:0] last, string tag);
    logic [7:0] e;
    e = {~last[7], tog_m, last[5:0]};
    tog_m = ~tog_m;
    rd(17'h0, e, tag);
  endtask

  task automatic wait_busy();
    while (!busy) @(negedge clk);
    tog_m = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected result actual=%0h expected=none", host_rdata);
      end else begin
        check(tag_q.pop_front(), {24'h0, host_rdata}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [16:0] b1, b2;
    rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_wr = 0; host_rd = 0;
    amem[32'h10] = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1 busy",     {31'h0, busy},     0);
    check("R1 rd_valid", {31'h0, rd_valid}, 0);
    check("R1 arr_we",   {31'h0, arr_we},   0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: plain reads
    rd(17'h10, 8'h5A, "R2 stored");
    rd(17'h20, 8'hFF, "R2 blank");

    // page load, out of order, with a foreign page strobe and a late byte
    b1 = {10'h0A5, 7'h0};
    amem[int'(b1) + 3] = 8'h33;
    amem[int'(b1) + 5] = 8'h55;
    amem[32'h1234]     = 8'h77;
    exp_page = 10'h0A5;
    we_cnt = 0;
    wr(b1 + 5, 8'hA1);
    wr(17'h1234, 8'h00);                  // R4 foreign page
    wr(b1 + 2, 8'hB2);
    repeat (W - 2) @(negedge clk);
    wr(b1 + 100, 8'h4C);                  // R5 arrives on the last window cycle
    repeat (W - 1) @(negedge clk);
    check("R5 busy before window end", {31'h0, busy}, 0);
    @(negedge clk);
    check("R5 busy at window end", {31'h0, busy}, 1);
    repeat (P - 1) @(negedge clk);
    check("R6 busy last cycle", {31'h0, busy}, 1);
    @(negedge clk);
    check("R6 busy released", {31'h0, busy}, 0);
    check("R11 commit count", we_cnt, 3);
    check("R11 commit page", we_badpage, 0);
    rd(b1 + 5,   8'hA1, "R3 offset5");
    rd(b1 + 2,   8'hB2, "R3 offset2");
    rd(b1 + 100, 8'h4C, "R5 late byte");
    rd(b1 + 3,   8'h33, "R3 untouched");
    rd(17'h1234, 8'h77, "R4 foreign ignored");

    // second page: repeated offset, status reads, writes while busy
    b2 = {10'h1F0, 7'h0};
    exp_page = 10'h1F0;
    we_cnt = 0;
    wr(b2 + 1, 8'h90);
    wr(b2 + 7, 8'h11);
    wr(b2 + 7, 8'h3C);
    wait_busy();
    rd_stat(8'h3C, "R7 R8 status0");
    wr(b2 + 9, 8'h66);                    // R9 ignored
    rd_stat(8'h3C, "R7 R8 status1");
    wr(17'h0040, 8'h12);                  // R9 ignored
    rd_stat(8'h3C, "R7 R8 status2");
    wait_idle();
    check("R11 commit count p2", we_cnt, 2);
    check("R11 commit page p2", we_badpage, 0);
    rd(b2 + 7, 8'h3C, "R3 R10 newest value");
    rd(b2 + 1, 8'h90, "R10 data");
    rd(b2 + 9, 8'hFF, "R9 busy write dropped");
    rd(17'h0040, 8'hFF, "R9 busy write dropped other");

    // new cycle after completion, last byte with bit7 set
    we_cnt = 0;
    wr(b2 + 9, 8'hC5);
    wait_busy();
    rd_stat(8'hC5, "R7 R8 restart0");
    rd_stat(8'hC5, "R7 R8 restart1");
    wait_idle();
    check("R11 commit count p3", we_cnt, 1);
    rd(b2 + 9, 8'hC5, "R10 new cycle");

    repeat (4) @(negedge clk);
    check("R2 all results seen", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule